// File: doc/BRIEF.md
# UART Transmit Engine with Flow Control

This block turns bytes into asynchronous serial frames on a single transmit line. Bytes are written into a 64-entry buffer. A configuration input can cut that buffer down to a single holding register. A frame shifter takes one byte at a time and sends it with a programmable word length, parity rule and stop-bit count. The bit timing comes from an external 16x oversampling enable, so one bit lasts 16 pulses of `tick_i`.

Software or a DMA engine refills the buffer when `tx_req_o` asks for more data. The request can be a one-cycle pulse when the shifter takes a byte and the buffer has fallen below a threshold, or a level that follows the buffer fill. An optional hardware handshake holds back the start of each new frame until the active-low clear-to-send input is asserted. A break control holds the line low once the frame in flight has finished. Status outputs report an empty buffer, a fully idle transmitter, and the synchronized clear-to-send state with a sticky change flag.

Top module: `utx_core`

## Requirements
- R1: The line idles at 1. A frame is a start bit of 0, then the data bits LSB first, then the stop bits of 1, with each bit lasting 16 `tick_i` pulses. `cfg_wlen_i` picks the data bits (00=5, 01=6, 10=7, 11=8). `cfg_stop2_i`=1 gives two stop bits and 0 gives one.
- R2: With `cfg_par_i[2]`=0 no parity bit is sent. With it set, a parity bit follows the data bits. `cfg_par_i[1:0]` picks the rule: 00 makes the count of ones over data and parity odd, 01 makes it even, 10 sends a constant 1 and 11 sends a constant 0.
- R3: While `cfg_break_i`=1, the line is driven to 0 and no byte is taken from the buffer. A frame already in progress when break is requested is completed first, and normal sending resumes once break drops.
- R4: With `cfg_afc_i`=1, a new frame starts only while `cts_ni` (after a 2-flop synchronizer) is low. A frame already started always completes. With `cfg_afc_i`=0, `cts_ni` has no effect on sending.
- R5: In FIFO mode (`cfg_fifo_en_i`=1) the buffer holds 64 bytes and sends them in write order. `fifo_cnt_o` shows the count modulo 64 and `fifo_full_o` is 1 at 64 entries. A write while full is ignored.
- R6: A one-cycle `fifo_clr_i` empties the buffer. It wins over a write in the same cycle.
- R7: In non-FIFO mode the buffer is a single holding register. `fifo_full_o` is 1 while it is occupied, and a write while it is occupied is ignored.
- R8: With `cfg_level_i`=0, `tx_req_o` pulses for one cycle, in the cycle after the shifter takes a byte. In FIFO mode the pulse comes only if the count left after the take is below the limit that `cfg_thr_i` selects (00=1, i.e. empty, 01=16, 10=32, 11=48). In non-FIFO mode every take pulses.
- R9: With `cfg_level_i`=1, `tx_req_o` follows, one cycle late, whether the FIFO count is below the selected limit. In non-FIFO mode it follows whether the holding register is empty.
- R10: `buf_empty_o` is 1 when the buffer holds no byte. `tx_empty_o` is 1 only when the buffer is empty and no frame is on the line. Both are 1 out of reset.
- R11: `cts_o` is the synchronized asserted state of `cts_ni`. `dcts_o` is set by any change of that state and cleared by `stat_rd_i`, and a change wins over a clear in the same cycle.
- R12: A write and a take by the shifter in the same cycle both take effect, leaving the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 16x oversampling enable |
| cfg_wlen_i | input | 2 | Data bit count code |
| cfg_par_i | input | 3 | Parity mode code |
| cfg_stop2_i | input | 1 | Two stop bits when 1 |
| cfg_break_i | input | 1 | Send break |
| cfg_afc_i | input | 1 | Automatic flow control enable |
| cfg_fifo_en_i | input | 1 | FIFO mode when 1, holding register when 0 |
| cfg_thr_i | input | 2 | Request threshold code |
| cfg_level_i | input | 1 | Level request when 1, pulse when 0 |
| wr_valid_i | input | 1 | Write a byte into the buffer |
| wr_data_i | input | 8 | Byte to write |
| fifo_clr_i | input | 1 | Empty the buffer |
| cts_ni | input | 1 | Clear-to-send, active low |
| stat_rd_i | input | 1 | Status read, clears the CTS change flag |
| txd_o | output | 1 | Serial transmit line |
| tx_req_o | output | 1 | Interrupt or DMA request |
| buf_empty_o | output | 1 | Buffer empty |
| tx_empty_o | output | 1 | Buffer and shifter empty |
| fifo_cnt_o | output | 6 | Buffer count modulo 64 |
| fifo_full_o | output | 1 | Buffer full |
| cts_o | output | 1 | Synchronized clear-to-send asserted |
| dcts_o | output | 1 | Clear-to-send changed since last status read |

## Verification
Two events can land on the same clock edge: a buffer write and the shifter taking the oldest byte. The bench holds one byte back with flow control, then releases clear-to-send while writing on four consecutive cycles. That window is sure to cover the synchronizer delay before the take. It then expects the count to read exactly four, and expects all five bytes on the line in write order. A second overlap, clear against write, is judged by the buffer reading empty afterwards.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {TX_IDLE = 2'd0, TX_SEND = 2'd1, TX_BRK = 2'd2} tx_state_e;

  localparam int FRAME_W = 12;

  function automatic logic [FRAME_W-1:0] frame_bits(input logic [7:0] d,
                                                    input logic [1:0] wlen,
                                                    input logic [2:0] par);
    logic [FRAME_W-1:0] v;
    logic [7:0] m;
    logic p;
    int nd;
    nd = 5 + int'(wlen);
    m = 8'hFF >> (2'd3 - wlen);
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) v[i+1] = d[i];
    end
    case (par[1:0])
      2'b00:   p = ~^(d & m);
      2'b01:   p = ^(d & m);
      2'b10:   p = 1'b1;
      default: p = 1'b0;
    endcase
    if (par[2]) v[nd+1] = p;
    return v;
  endfunction

  function automatic logic [3:0] frame_len(input logic [1:0] wlen, input logic par_en,
                                           input logic stop2);
    return 4'd7 + {2'b00, wlen} + {3'b000, par_en} + {3'b000, stop2};
  endfunction
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          single_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cap;
  logic          wr_ok, rd_ok;

  assign cap   = single_i ? CW'(1) : CW'(DEPTH);
  assign wr_ok = wr_i && !clr_i && (cnt_q < cap);
  assign rd_ok = rd_i && !clr_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (rd_ok) rp_q <= rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == cap);

  // R5
  wr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && !clr_i && full_o) |=> $stable(cnt_q));
  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R6
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int OSR  = 16,
  localparam int TW  = $clog2(OSR)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] wlen_i,
  input  logic [2:0] par_i,
  input  logic       stop2_i,
  input  logic       brk_i,
  input  logic       afc_i,
  input  logic       cts_i,
  input  logic       avail_i,
  input  logic [7:0] data_i,
  output logic       load_o,
  output logic       busy_o,
  output logic       txd_o
);
  tx_state_e          state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [3:0]         left_q;
  logic [TW-1:0]      tick_q;

  assign load_o = (state_q == TX_IDLE) && !brk_i && avail_i && (!afc_i || cts_i);
  assign busy_o = (state_q == TX_SEND);
  assign txd_o  = busy_o ? frame_q[0] : (state_q != TX_BRK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      frame_q <= '1;
      left_q  <= '0;
      tick_q  <= '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (brk_i) begin
            state_q <= TX_BRK;
          end else if (load_o) begin
            state_q <= TX_SEND;
            frame_q <= frame_bits(data_i, wlen_i, par_i);
            left_q  <= frame_len(wlen_i, par_i[2], stop2_i);
            tick_q  <= '0;
          end
        end
        TX_SEND: begin
          if (tick_i) begin
            if (tick_q == TW'(OSR - 1)) begin
              tick_q <= '0;
              if (left_q == 4'd1) begin
                state_q <= TX_IDLE;
              end else begin
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                left_q  <= left_q - 4'd1;
              end
            end else begin
              tick_q <= tick_q + 1'b1;
            end
          end
        end
        TX_BRK:  if (!brk_i) state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  // R1
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);
  // R1
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(txd_o));
  // R3
  brk_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !busy_o) |=> (!txd_o || !brk_i));
  // R4
  afc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && afc_i) |-> $past(cts_i));
endmodule

// File: rtl/utx_req.sv
module utx_req #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          fifo_en_i,
  input  logic [1:0]    thr_i,
  input  logic          level_i,
  output logic          req_o
);
  logic [CW-1:0] lim, left;
  logic          pulse_ev, lvl, req_q;

  assign lim      = (thr_i == 2'b00) ? CW'(1) : CW'(int'(thr_i) * (DEPTH / 4));
  assign left     = cnt_i - 1'b1;
  assign pulse_ev = load_i && (!fifo_en_i || (left < lim));
  assign lvl      = fifo_en_i ? (cnt_i < lim) : (cnt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= level_i ? lvl : pulse_ev;
  end

  assign req_o = req_q;

  // R8
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && $past(!level_i) && req_q) |=> !req_q);
endmodule

// File: rtl/utx_cts.sv
module utx_cts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_ni,
  input  logic stat_rd_i,
  output logic cts_o,
  output logic dcts_o
);
  logic s1_q, s2_q, prev_q, dcts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b0;
      dcts_q <= 1'b0;
    end else begin
      s1_q   <= cts_ni;
      s2_q   <= s1_q;
      prev_q <= ~s2_q;
      if (~s2_q != prev_q) dcts_q <= 1'b1;
      else if (stat_rd_i)  dcts_q <= 1'b0;
    end
  end

  assign cts_o  = ~s2_q;
  assign dcts_o = dcts_q;

  // R11
  dcts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(s2_q) |=> dcts_q);
endmodule

// File: rtl/utx_core.sv
module utx_core #(
  parameter int DEPTH = 64,
  parameter int OSR   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [1:0]    cfg_wlen_i,
  input  logic [2:0]    cfg_par_i,
  input  logic          cfg_stop2_i,
  input  logic          cfg_break_i,
  input  logic          cfg_afc_i,
  input  logic          cfg_fifo_en_i,
  input  logic [1:0]    cfg_thr_i,
  input  logic          cfg_level_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          fifo_clr_i,
  input  logic          cts_ni,
  input  logic          stat_rd_i,
  output logic          txd_o,
  output logic          tx_req_o,
  output logic          buf_empty_o,
  output logic          tx_empty_o,
  output logic [AW-1:0] fifo_cnt_o,
  output logic          fifo_full_o,
  output logic          cts_o,
  output logic          dcts_o
);
  logic [CW-1:0] cnt;
  logic [7:0]    head;
  logic          load, busy, cts_act;

  utx_cts u_cts (
    .clk_i, .rst_ni, .cts_ni, .stat_rd_i,
    .cts_o(cts_act), .dcts_o
  );

  utx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i, .rst_ni,
    .clr_i(fifo_clr_i), .single_i(!cfg_fifo_en_i),
    .wr_i(wr_valid_i), .wdata_i(wr_data_i),
    .rd_i(load), .rdata_o(head),
    .cnt_o(cnt), .full_o(fifo_full_o)
  );

  utx_shifter #(.OSR(OSR)) u_shift (
    .clk_i, .rst_ni, .tick_i,
    .wlen_i(cfg_wlen_i), .par_i(cfg_par_i), .stop2_i(cfg_stop2_i),
    .brk_i(cfg_break_i), .afc_i(cfg_afc_i), .cts_i(cts_act),
    .avail_i(cnt != '0), .data_i(head),
    .load_o(load), .busy_o(busy), .txd_o
  );

  utx_req #(.DEPTH(DEPTH)) u_req (
    .clk_i, .rst_ni, .load_i(load), .cnt_i(cnt),
    .fifo_en_i(cfg_fifo_en_i), .thr_i(cfg_thr_i), .level_i(cfg_level_i),
    .req_o(tx_req_o)
  );

  assign cts_o       = cts_act;
  assign buf_empty_o = (cnt == '0);
  assign tx_empty_o  = buf_empty_o && !busy;
  assign fifo_cnt_o  = cnt[AW-1:0];

  // R10
  empty_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> buf_empty_o);
  // R12
  same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && wr_valid_i && !fifo_clr_i && !fifo_full_o) |=> $stable(cnt));
endmodule

// File: tb/utx_core_tb.sv
module utx_core_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic       tick = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic [2:0] par = 3'd0;
  logic       stop2 = 1'b0, brk = 1'b0, afc = 1'b0, fifo_en = 1'b1, level = 1'b0;
  logic [1:0] thr = 2'd0;
  logic       wr = 1'b0, clr = 1'b0, cts_n = 1'b1, srd = 1'b0;
  logic [7:0] wdata = '0;
  logic       txd, req, bempty, tempty, full, cts, dcts;
  logic [5:0] cnt;

  utx_core u_dut (
    .clk_i(clk), .rst_ni, .tick_i(tick),
    .cfg_wlen_i(wlen), .cfg_par_i(par), .cfg_stop2_i(stop2), .cfg_break_i(brk),
    .cfg_afc_i(afc), .cfg_fifo_en_i(fifo_en), .cfg_thr_i(thr), .cfg_level_i(level),
    .wr_valid_i(wr), .wr_data_i(wdata), .fifo_clr_i(clr), .cts_ni(cts_n),
    .stat_rd_i(srd), .txd_o(txd), .tx_req_o(req), .buf_empty_o(bempty),
    .tx_empty_o(tempty), .fifo_cnt_o(cnt), .fifo_full_o(full), .cts_o(cts),
    .dcts_o(dcts)
  );

  int n_run = 0, n_fail = 0, frames = 0, req_cnt = 0;
  bit mon_en = 1'b1, mon_busy = 1'b0, done = 1'b0;
  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // 16x tick every 4 clocks: one bit = 64 clocks
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  initial forever begin
    @(negedge clk);
    if (req && !level) req_cnt++;
  end

  function automatic logic [15:0] model_frame(input logic [7:0] d);
    logic [11:0] b = '0;
    int k = 0, ones = 0, n;
    n = 5 + int'(wlen);
    b[k] = 1'b0; k++;
    for (int i = 0; i < n; i++) begin
      b[k] = d[i]; k++;
      if (d[i]) ones++;
    end
    if (par[2]) begin
      case (par[1:0])
        2'd0: b[k] = (ones % 2 == 0);
        2'd1: b[k] = (ones % 2 == 1);
        2'd2: b[k] = 1'b1;
        default: b[k] = 1'b0;
      endcase
      k++;
    end
    b[k] = 1'b1; k++;
    if (stop2) begin b[k] = 1'b1; k++; end
    return {4'(k), b};
  endfunction

  // frame monitor: samples mid-bit
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_en && prev && !txd) begin
        mon_busy = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected frame", 0, 1);
        end else begin
          logic [15:0] e;
          logic [11:0] got = '1;
          logic [11:0] msk;
          int len;
          e = exp_q.pop_front();
          len = int'(e[15:12]);
          repeat (32) @(negedge clk);
          got[0] = txd;
          for (int b = 1; b < len; b++) begin
            repeat (64) @(negedge clk);
            got[b] = txd;
          end
          msk = 12'((1 << len) - 1);
          // R1 R2 R5: bits, parity, order
          chk((got & msk) == (e[11:0] & msk), "R1/R2/R5 frame bits",
              int'(got & msk), int'(e[11:0] & msk));
          frames++;
        end
        mon_busy = 1'b0;
      end
      prev = txd;
    end
  end

  task automatic wr_byte(input logic [7:0] d, input bit accept);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    if (accept) exp_q.push_back(model_frame(d));
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!(tempty && exp_q.size() == 0 && !mon_busy) && t < 30000);
    chk(t < 30000, "R1 drain", t, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic set_cts(input logic v);
    @(negedge clk);
    cts_n = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(txd == 1'b1, "R1 idle line", txd, 1);
    chk(bempty == 1'b1 && tempty == 1'b1, "R10 reset empties", {bempty, tempty}, 3);
    chk(cnt == 0 && full == 0, "R5 reset count", cnt, 0);
    chk(req == 0 && dcts == 0, "R8 reset req", {req, dcts}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2: random frame formats
    for (int p = 0; p < 7; p++) begin
      int n;
      wlen = 2'($urandom % 4);
      par = (p < 4) ? {1'b1, 2'(p)} : 3'($urandom % 8);
      stop2 = 1'($urandom % 2);
      n = 3 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wr_byte(8'($urandom), 1'b1);
      wait_idle();
    end
    wlen = 2'd3; par = 3'd0; stop2 = 1'b0;

    // R10 mid-frame status
    wr_byte(8'h81, 1'b1);
    repeat (10) @(negedge clk);
    chk(bempty == 1 && tempty == 0, "R10 busy shifter", {bempty, tempty}, 2);
    wait_idle();
    chk(tempty == 1, "R10 idle again", tempty, 1);

    // R4 flow control
    afc = 1'b1;
    set_cts(1'b1);
    wr_byte(8'h5A, 1'b1);
    repeat (200) @(negedge clk);
    chk(txd == 1 && bempty == 0, "R4 held by cts", {txd, bempty}, 2);
    set_cts(1'b0);
    wait_idle();
    begin
      int f0;
      wr_byte(8'h12, 1'b1);
      wr_byte(8'h34, 1'b1);
      f0 = frames;
      repeat (30) @(negedge clk);
      cts_n = 1'b1;
      while (frames == f0) @(negedge clk);
      repeat (150) @(negedge clk);
      chk(cnt == 1, "R4 in-flight frame completes, next held", cnt, 1);
      set_cts(1'b0);
      wait_idle();
    end
    afc = 1'b0;
    set_cts(1'b1);
    wr_byte(8'hC3, 1'b1);
    wait_idle();
    chk(frames > 0 && exp_q.size() == 0, "R4 cts ignored without afc", exp_q.size(), 0);

    // R5 R6 fill, overflow, clear
    afc = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      wr = 1'b1; wdata = 8'(i);
      @(negedge clk);
    end
    wr = 1'b0;
    chk(cnt == 0 && full == 1, "R5 full at 64", {full, cnt}, 64);
    wr_byte(8'hEE, 1'b0);
    chk(cnt == 0 && full == 1 && bempty == 0, "R5 write when full ignored", {full, cnt}, 64);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(cnt == 0 && full == 0 && bempty == 1, "R6 clear empties", {full, cnt}, 0);
    wr_byte(8'h01, 1'b0);
    chk(cnt == 1, "R5 count one", cnt, 1);
    wr = 1'b1; clr = 1'b1; wdata = 8'h02;
    @(negedge clk);
    wr = 1'b0; clr = 1'b0;
    chk(cnt == 0 && bempty == 1, "R6 clear beats write", cnt, 0);

    // R8 pulse threshold 16
    thr = 2'd1;
    for (int i = 0; i < 20; i++) wr_byte(8'($urandom), 1'b1);
    req_cnt = 0;
    set_cts(1'b0);
    wait_idle();
    chk(req_cnt == 16, "R8 pulses below 16", req_cnt, 16);
    // R8 threshold empty
    set_cts(1'b1);
    thr = 2'd0;
    for (int i = 0; i < 3; i++) wr_byte(8'($urandom), 1'b1);
    req_cnt = 0;
    set_cts(1'b0);
    wait_idle();
    chk(req_cnt == 1, "R8 pulse on empty only", req_cnt, 1);

    // R7 non-FIFO holding register
    set_cts(1'b1);
    fifo_en = 1'b0;
    wr_byte(8'h11, 1'b1);
    wr_byte(8'h22, 1'b0);
    chk(cnt == 1 && full == 1, "R7 holding occupied, write ignored", {full, cnt}, 65);
    req_cnt = 0;
    set_cts(1'b0);
    wait_idle();
    chk(req_cnt == 1, "R8 non-FIFO pulse per take", req_cnt, 1);
    fifo_en = 1'b1;

    // R9 level mode
    level = 1'b1; thr = 2'd0;
    repeat (3) @(negedge clk);
    chk(req == 1, "R9 level when empty", req, 1);
    set_cts(1'b1);
    wr_byte(8'h77, 1'b1);
    repeat (2) @(negedge clk);
    chk(req == 0, "R9 level drops with one byte", req, 0);
    thr = 2'd1;
    repeat (2) @(negedge clk);
    chk(req == 1, "R9 level below 16", req, 1);
    set_cts(1'b0);
    wait_idle();
    level = 1'b0; thr = 2'd0;

    // R12 write and take in same cycle
    set_cts(1'b1);
    wr_byte(8'hA1, 1'b1);
    @(negedge clk);
    cts_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      wr = 1'b1; wdata = 8'hB0 + 8'(i);
      exp_q.push_back(model_frame(wdata));
      @(negedge clk);
    end
    wr = 1'b0;
    chk(cnt == 4 && tempty == 0, "R12 write and take together", cnt, 4);
    wait_idle();

    // R3 break
    afc = 1'b0;
    wr_byte(8'hA5, 1'b1);
    repeat (20) @(negedge clk);
    brk = 1'b1;
    mon_en = 1'b0;
    while (!tempty) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(txd == 0, "R3 break after frame", txd, 0);
    chk(frames > 0 && exp_q.size() == 0, "R3 in-flight frame sent", exp_q.size(), 0);
    wr_byte(8'h3C, 1'b0);
    repeat (300) @(negedge clk);
    chk(bempty == 0 && txd == 0, "R3 no take during break", {bempty, txd}, 0);
    exp_q.push_back(model_frame(8'h3C));
    mon_en = 1'b1;
    brk = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R3 resumes after break", exp_q.size(), 0);

    // R11 cts change flag
    srd = 1'b1; @(negedge clk); srd = 1'b0;
    @(negedge clk);
    chk(dcts == 0, "R11 flag cleared", dcts, 0);
    set_cts(1'b1);
    chk(dcts == 1 && cts == 0, "R11 change seen", {dcts, cts}, 2);
    srd = 1'b1; @(negedge clk); srd = 1'b0;
    @(negedge clk);
    chk(dcts == 0, "R11 read clears", dcts, 0);
    set_cts(1'b0);
    chk(dcts == 1 && cts == 1, "R11 assert seen", {dcts, cts}, 3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule